// File: doc/BRIEF.md
# Clocked read sequencer for an asynchronous byte-wide ROM

This block sits between a synchronous on-chip bus and an external read-only memory that has no clock of its own. The memory holds 4,194,304 bytes behind a 22-bit address, an active-low chip select and an active-low output gate. It drives its data pins only while both strobes are low. A requester presents an address on a valid/ready handshake. The sequencer puts the address on the pins, pulls the chip select low, and opens the output gate at a computed point. It counts clock cycles until every access-time limit of the chosen speed grade has passed, captures the byte, and returns it with a one-cycle response strobe.

The address, chip-select and output-gate access times and the bus-float time come from a speed-grade parameter. Each is converted to a cycle count from a clock-period parameter: the ceiling of time over period, plus one margin cycle. The access window is the largest of the address count, the chip-select count and the output-gate count plus one. The output gate opens when the window minus the output-gate count has passed. A request that arrives while a response is being returned keeps the chip select low and only moves the address. Otherwise both strobes rise and the sequencer refuses new work until the float interval has run out, so the data pins are released before another driver may use them.

Top module: `romrd_ctrl`

## Requirements
- R1: During and right after reset (asynchronous, active-low), chip select and output gate are high, request ready is high and response valid is low. A reset in the middle of an access returns to this state at once.
- R2: A request is taken on a clock edge where request valid and request ready are both high. After that edge the address pins carry the request address, chip select is low, the output gate is high and request ready is low.
- R3: The output gate falls exactly OE_START cycles after the edge that put the address on the pins. OE_START is the window minus the output-gate count (12 cycles for the fastest grade at a 4 ns clock).
- R4: Response valid is high for exactly one cycle, beginning exactly ACC cycles after the address edge (26 for the fastest grade at 4 ns). Response data equals the byte the memory drives for that address with both strobes low.
- R5: The capturing edge changes neither the address pins nor the output gate. Both hold their values through the cycle in which response valid is high.
- R6: Request ready is high while response valid is high. A request taken then leaves chip select low. On the next edge it raises the output gate and puts the new address on the pins, and the new access then runs its full ACC-cycle window.
- R7: With no request taken during the response cycle, both strobes rise on the next edge. Request ready then stays low for exactly FLOAT cycles (6 for the fastest grade at 4 ns) before returning high.
- R8: The output gate is never low while chip select is high.
- R9: SPEED_GRADE selects the timings. 0 gives 100/100/50/20 ns, 1 gives 120/120/60/20 ns and 2 gives 150/150/70/30 ns for address, chip-select, output-gate and float. At 4 ns, grade 2 gives ACC 39, OE_START 20 and FLOAT 9.
- R10: While request ready is low, request valid and the request address have no effect: the address pins keep the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | One-cycle strobe with the read byte |
| rsp_data | output | DATA_W | Byte read from the memory |
| rom_addr | output | ADDR_W | Address pins of the memory |
| rom_ce_n | output | 1 | Active-low chip select |
| rom_oe_n | output | 1 | Active-low output gate |
| rom_data | input | DATA_W | Data pins of the memory |

## Verification
Single reads are tried at all-zero, all-ones, alternating-bit and single-bit addresses. These show up any address bit that is dropped or swapped, because the model's byte is a fold of all address bits. Chained pairs show whether the chip select is held low and the full window is repeated. Isolated reads show the strobe release and the exact float gap. The memory model returns a wrong byte until every access time has passed in nanoseconds, measured from the pin edges. A window one cycle short therefore shows up as bad data, not only as a count mismatch. A second instance at the slowest grade tells a real parameter-driven conversion apart from fixed counts. A request held high during a busy access, and a reset in the middle of an access, show that the sequencer ignores requests while busy and recovers from reset.

// File: rtl/romrd_pkg.sv
`timescale 1ns/1ps
package romrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_OPEN  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_FLOAT = 3'd4
    } romrd_state_e;

    // address access time in ns for a speed grade
    function automatic int unsigned grade_t_addr(input int unsigned g);
        case (g)
            1:       return 120;
            2:       return 150;
            default: return 100;
        endcase
    endfunction

    // chip-select access time in ns
    function automatic int unsigned grade_t_sel(input int unsigned g);
        case (g)
            1:       return 120;
            2:       return 150;
            default: return 100;
        endcase
    endfunction

    // output-gate access time in ns
    function automatic int unsigned grade_t_gate(input int unsigned g);
        case (g)
            1:       return 60;
            2:       return 70;
            default: return 50;
        endcase
    endfunction

    // time for the pins to stop driving after a strobe rises
    function automatic int unsigned grade_t_float(input int unsigned g);
        case (g)
            2:       return 30;
            default: return 20;
        endcase
    endfunction

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period,
                                                 input int unsigned margin);
        return (ns + period - 1) / period + margin;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/romrd_seq.sv
`timescale 1ns/1ps
module romrd_seq
    import romrd_pkg::*;
#(
    parameter int unsigned ACC_CNT   = 26,
    parameter int unsigned OE_START  = 12,
    parameter int unsigned FLOAT_CNT = 6,
    parameter int unsigned CNT_W     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic ce_n,
    output logic oe_n,
    output logic load_addr,
    output logic capture
);

    localparam logic [CNT_W-1:0] ACC_C   = CNT_W'(ACC_CNT);
    localparam logic [CNT_W-1:0] OPEN_C  = CNT_W'(OE_START);
    localparam logic [CNT_W-1:0] FLOAT_C = CNT_W'(FLOAT_CNT);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        romrd_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic             ce_n;
        logic             oe_n;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ready_w;
    logic take_w;
    logic cap_w;

    always_comb begin
        seq_d   = seq_q;
        ready_w = (seq_q.state == ST_IDLE) || (seq_q.state == ST_HOLD);
        take_w  = ready_w && req_valid;
        cap_w   = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                seq_d.ce_n = 1'b1;
                seq_d.oe_n = 1'b1;
                if (req_valid) begin
                    seq_d.state = ST_ADDR;
                    seq_d.cnt   = ONE_C;
                    seq_d.ce_n  = 1'b0;
                end
            end
            ST_ADDR: begin
                seq_d.cnt = seq_q.cnt + ONE_C;
                if (seq_q.cnt == OPEN_C) begin
                    seq_d.oe_n  = 1'b0;
                    seq_d.state = ST_OPEN;
                end
            end
            ST_OPEN: begin
                seq_d.cnt = seq_q.cnt + ONE_C;
                if (seq_q.cnt == ACC_C) begin
                    cap_w       = 1'b1;
                    seq_d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                seq_d.cnt  = ONE_C;
                seq_d.oe_n = 1'b1;
                if (req_valid) begin
                    seq_d.state = ST_ADDR;
                end else begin
                    seq_d.ce_n  = 1'b1;
                    seq_d.state = ST_FLOAT;
                end
            end
            ST_FLOAT: begin
                seq_d.cnt = seq_q.cnt + ONE_C;
                if (seq_q.cnt == FLOAT_C) begin
                    seq_d.state = ST_IDLE;
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
                seq_d.ce_n  = 1'b1;
                seq_d.oe_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.cnt   <= '0;
            seq_q.ce_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = ready_w;
    assign load_addr = take_w;
    assign capture   = cap_w;
    assign ce_n      = seq_q.ce_n;
    assign oe_n      = seq_q.oe_n;

endmodule

// File: rtl/romrd_dpath.sv
`timescale 1ns/1ps
module romrd_dpath #(
    parameter int unsigned ADDR_W = 22,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              capture,
    input  logic [DATA_W-1:0] rom_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              valid;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d       = dp_q;
        dp_d.valid = capture;
        if (load_addr) begin
            dp_d.addr = req_addr;
        end
        if (capture) begin
            dp_d.data = rom_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q.addr  <= '0;
            dp_q.data  <= '0;
            dp_q.valid <= 1'b0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign rom_addr  = dp_q.addr;
    assign rsp_valid = dp_q.valid;
    assign rsp_data  = dp_q.data;

endmodule

// File: rtl/romrd_ctrl.sv
`timescale 1ns/1ps
module romrd_ctrl
    import romrd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter int unsigned SYNC_MARGIN   = 1,
    parameter int unsigned ADDR_W        = 22,
    parameter int unsigned DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [DATA_W-1:0] rom_data
);

    localparam int unsigned ADDR_CNT  = ns_to_cycles(grade_t_addr(SPEED_GRADE),  CLK_PERIOD_NS, SYNC_MARGIN);
    localparam int unsigned SEL_CNT   = ns_to_cycles(grade_t_sel(SPEED_GRADE),   CLK_PERIOD_NS, SYNC_MARGIN);
    localparam int unsigned GATE_CNT  = ns_to_cycles(grade_t_gate(SPEED_GRADE),  CLK_PERIOD_NS, SYNC_MARGIN);
    localparam int unsigned RAW_FLOAT = ns_to_cycles(grade_t_float(SPEED_GRADE), CLK_PERIOD_NS, SYNC_MARGIN);
    localparam int unsigned FLOAT_CNT = max_of(RAW_FLOAT, 1);
    localparam int unsigned ACC_CNT   = max_of(max_of(ADDR_CNT, SEL_CNT), GATE_CNT + 1);
    localparam int unsigned OE_START  = ACC_CNT - GATE_CNT;
    localparam int unsigned CNT_W     = $clog2(max_of(ACC_CNT, FLOAT_CNT) + 2);

    logic load_w;
    logic cap_w;

    romrd_seq #(
        .ACC_CNT  (ACC_CNT),
        .OE_START (OE_START),
        .FLOAT_CNT(FLOAT_CNT),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .ce_n     (rom_ce_n),
        .oe_n     (rom_oe_n),
        .load_addr(load_w),
        .capture  (cap_w)
    );

    romrd_dpath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_addr(load_w),
        .req_addr (req_addr),
        .capture  (cap_w),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

endmodule

// File: rtl/romrd_ctrl_chk.sv
`timescale 1ns/1ps
module romrd_ctrl_chk #(
    parameter int unsigned ADDR_W   = 22,
    parameter int unsigned ACC_CNT  = 26,
    parameter int unsigned OE_START = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_ce_n,
    input logic              rom_oe_n
);

    // cycles since the last accepted request, saturating
    logic [15:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (req_valid && req_ready) begin
            since_q <= 16'd1;
        end else if (since_q != 16'd0 && since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!rom_ce_n && rom_oe_n && !req_ready));

    assert_gate_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_oe_n) |-> (since_q == 16'(OE_START + 1)));

    assert_rsp_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (since_q == 16'(ACC_CNT + 1)));

    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($stable(rom_addr) && !rom_oe_n));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_ce_n) |-> (!req_ready && rom_oe_n));

    assert_gate_needs_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n |-> rom_oe_n);

    assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(rom_addr));

endmodule

bind romrd_ctrl romrd_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .ACC_CNT (ACC_CNT),
    .OE_START(OE_START)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rom_addr (rom_addr),
    .rom_ce_n (rom_ce_n),
    .rom_oe_n (rom_oe_n)
);

// File: tb/romrd_ctrl_tb.sv
`timescale 1ns/1ps
// Behavioural memory: output is valid only when every access time has passed
module romrd_rom_tbm #(
    parameter int T_ADDR = 100,
    parameter int T_SEL  = 100,
    parameter int T_GATE = 50
) (
    input  logic        clk,
    input  logic [21:0] addr,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic [7:0]  truth,
    output logic [7:0]  data
);
    longint t_a = 0;
    longint t_s = 0;
    longint t_g = 0;

    always @(addr)         t_a = $time;
    always @(negedge ce_n) t_s = $time;
    always @(negedge oe_n) t_g = $time;

    always @(negedge clk) begin
        if (!ce_n && !oe_n && ($time - t_a >= T_ADDR) &&
            ($time - t_s >= T_SEL) && ($time - t_g >= T_GATE))
            data <= truth;
        else
            data <= ~truth;
    end
endmodule

module romrd_ctrl_tb;

    localparam int P = 4;

    function automatic int cyc(input int ns);
        return (ns + P - 1) / P + 1;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_ACC0  = imax(imax(cyc(100), cyc(100)), cyc(50) + 1);
    localparam int E_OES0  = E_ACC0 - cyc(50);
    localparam int E_FLT0  = cyc(20);
    localparam int E_ACC2  = imax(imax(cyc(150), cyc(150)), cyc(70) + 1);
    localparam int E_OES2  = E_ACC2 - cyc(70);
    localparam int E_FLT2  = cyc(30);

    function automatic logic [7:0] tb_byte(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'hA5;
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(P/2) clk = ~clk;

    logic        rv0 = 1'b0, rv1 = 1'b0;
    logic [21:0] req_addr = '0;
    logic        rdy0, rdy1, rsp0, rsp1, ce0, ce1, oe0, oe1;
    logic [7:0]  rd0, rd1, md0, md1;
    logic [21:0] ra0, ra1;

    romrd_ctrl #(.CLK_PERIOD_NS(P), .SPEED_GRADE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv0), .req_ready(rdy0),
        .req_addr(req_addr), .rsp_valid(rsp0), .rsp_data(rd0),
        .rom_addr(ra0), .rom_ce_n(ce0), .rom_oe_n(oe0), .rom_data(md0));

    romrd_ctrl #(.CLK_PERIOD_NS(P), .SPEED_GRADE(2)) u_dut_slow (
        .clk(clk), .rst_n(rst_n), .req_valid(rv1), .req_ready(rdy1),
        .req_addr(req_addr), .rsp_valid(rsp1), .rsp_data(rd1),
        .rom_addr(ra1), .rom_ce_n(ce1), .rom_oe_n(oe1), .rom_data(md1));

    romrd_rom_tbm #(.T_ADDR(100), .T_SEL(100), .T_GATE(50)) u_mem0 (
        .clk(clk), .addr(ra0), .ce_n(ce0), .oe_n(oe0), .truth(tb_byte(ra0)), .data(md0));
    romrd_rom_tbm #(.T_ADDR(150), .T_SEL(150), .T_GATE(70)) u_mem1 (
        .clk(clk), .addr(ra1), .ce_n(ce1), .oe_n(oe1), .truth(tb_byte(ra1)), .data(md1));

    // observed instance select
    logic        sel = 1'b0;
    logic        m_ready, m_rsp, m_ce, m_oe;
    logic [7:0]  m_data;
    logic [21:0] m_addr;
    always_comb begin
        m_ready = sel ? rdy1 : rdy0;
        m_rsp   = sel ? rsp1 : rsp0;
        m_ce    = sel ? ce1  : ce0;
        m_oe    = sel ? oe1  : oe0;
        m_data  = sel ? rd1  : rd0;
        m_addr  = sel ? ra1  : ra0;
    end

    int checks = 0;
    int errors = 0;
    int r8_viol = 0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (rst_n && ((ce0 && !oe0) || (ce1 && !oe1))) r8_viol++;
    end

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_valid(input logic v);
        if (sel) rv1 = v; else rv0 = v;
    endtask

    task automatic issue(input logic [21:0] a);
        req_addr = a;
        set_valid(1'b1);
        chk_eq("R2 ready before take", m_ready, 1);
        tick();
        set_valid(1'b0);
    endtask

    // called one negedge after the address edge
    task automatic track(input logic [21:0] a, input bit follow, input logic [21:0] na);
        int oe_at = 0;
        int rsp_at = 0;
        int lowc;
        int e_acc = sel ? E_ACC2 : E_ACC0;
        int e_oes = sel ? E_OES2 : E_OES0;
        int e_flt = sel ? E_FLT2 : E_FLT0;
        logic [7:0] got = '0;
        logic oe_at_rsp = 1'b1;
        logic [21:0] a_at_rsp = '0;
        chk_eq(sel ? "R9 R2 take" : "R2 take", {m_ce, m_oe, m_ready, m_addr},
               {1'b0, 1'b1, 1'b0, a});
        for (int n = 2; n <= e_acc + 3 && rsp_at == 0; n++) begin
            tick();
            if (!m_oe && oe_at == 0) oe_at = n;
            if (m_rsp) begin
                rsp_at = n; got = m_data; oe_at_rsp = m_oe; a_at_rsp = m_addr;
            end
        end
        chk_eq(sel ? "R9 R3 gate" : "R3 gate", oe_at, e_oes + 1);
        chk_eq(sel ? "R9 R4 latency" : "R4 latency", rsp_at, e_acc + 1);
        chk_eq(sel ? "R9 R4 data" : "R4 data", got, tb_byte(a));
        chk_eq("R5 hold", {oe_at_rsp, a_at_rsp}, {1'b0, a});
        if (follow) begin
            chk_eq("R6 ready in rsp", m_ready, 1);
            req_addr = na;
            set_valid(1'b1);
            tick();
            set_valid(1'b0);
            chk_eq("R6 chained", {m_ce, m_oe, m_rsp, m_addr}, {1'b0, 1'b1, 1'b0, na});
        end else begin
            tick();
            chk_eq("R7 release", {m_ce, m_oe, m_rsp, m_ready}, {1'b1, 1'b1, 1'b0, 1'b0});
            lowc = 1;
            for (int k = 0; k < 64 && !m_ready; k++) begin
                tick();
                if (!m_ready) lowc++;
            end
            chk_eq(sel ? "R9 R7 float" : "R7 float", lowc, e_flt);
        end
    endtask

    typedef struct packed {
        logic        s;
        logic        follow;
        logic [21:0] addr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 22'h000000},
        '{1'b0, 1'b0, 22'h3FFFFF},
        '{1'b0, 1'b1, 22'h155555},
        '{1'b0, 1'b1, 22'h2AAAAA},
        '{1'b0, 1'b0, 22'h000001},
        '{1'b0, 1'b0, 22'h200000},
        '{1'b1, 1'b1, 22'h0F0F0F},
        '{1'b1, 1'b0, 22'h30C30C}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit chained = 1'b0;
        // R1: reset state on both instances
        repeat (3) @(negedge clk);
        chk_eq("R1 reset fast", {ce0, oe0, rdy0, rsp0}, {1'b1, 1'b1, 1'b1, 1'b0});
        chk_eq("R1 reset slow", {ce1, oe1, rdy1, rsp1}, {1'b1, 1'b1, 1'b1, 1'b0});
        rst_n = 1'b1;
        tick();
        chk_eq("R1 after release", {ce0, oe0, rdy0, rsp0}, {1'b1, 1'b1, 1'b1, 1'b0});

        // vector table
        for (int i = 0; i < 8; i++) begin
            sel = VECS[i].s;
            if (!chained) issue(VECS[i].addr);
            track(VECS[i].addr, VECS[i].follow,
                  (i < 7) ? VECS[i + 1].addr : 22'h0);
            chained = VECS[i].follow;
        end

        // R10: request held high while busy is ignored, then taken in the response cycle
        sel = 1'b0;
        issue(22'h012345);
        req_addr = 22'h3ABCDE;
        rv0 = 1'b1;
        repeat (5) tick();
        chk_eq("R10 busy", {ra0, rdy0}, {22'h012345, 1'b0});
        for (int k = 0; k < 64 && !rsp0; k++) tick();
        chk_eq("R10 first data", rd0, tb_byte(22'h012345));
        tick();
        rv0 = 1'b0;
        chk_eq("R10 R6 second taken", {ce0, ra0}, {1'b0, 22'h3ABCDE});
        for (int k = 0; k < 64 && !rsp0; k++) tick();
        chk_eq("R10 second data", rd0, tb_byte(22'h3ABCDE));
        for (int k = 0; k < 64 && !rdy0; k++) tick();

        // R1: reset in the middle of an access
        issue(22'h0AAAAA);
        repeat (15) tick();
        rst_n = 1'b0;
        #1;
        chk_eq("R1 mid reset", {ce0, oe0, rdy0, rsp0}, {1'b1, 1'b1, 1'b1, 1'b0});
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        issue(22'h123456);
        track(22'h123456, 1'b0, 22'h0);

        chk_eq("R8 gate without select", r8_viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule